// File: doc/BRIEF.md
# Byte-to-Sample PCM Channel Deinterleaver

This block sits behind a byte-wide PCM data port. A host writes audio one byte per strobe. The block packs consecutive bytes into samples of one, two or three bytes. It hands each finished sample out with the index of the channel it belongs to, and the channel index advances round-robin over a run-time channel count.

A channel-sync control bit keeps the host and the receiver in step. The host drives the bit high and then low again. The byte that follows is then taken as the first byte of channel 0 (the left channel). Sample width and channel count are captured at that moment only, so the host can reconfigure at any time without disturbing a stream in progress. Downstream storage and processing sit outside this block.

Top module: `pcm_byte_deinterleaver`

## Requirements
- R1: While reset is active and until the first sample completes, `smp_valid` is 0 and `smp_data` and `smp_chan` are 0. The configuration in force before the first sync toggle is 1-byte samples on 2 channels.
- R2: A high-to-low transition of `sync_bit`, seen on two successive clock edges, resets the byte position and the channel position. The next accepted byte then starts channel 0.
- R3: A write strobe in a cycle where `sync_bit` is 1 is discarded. It produces no sample and does not advance the byte or channel position.
- R4: Bytes are packed most significant first, and the sample is left-justified in 24 bits. The first byte lands in bits 23:16, the second in 15:8 and the third in 7:0. Bits below the last byte of the sample are 0.
- R5: `smp_valid` is high for exactly one cycle, in the cycle after the write that carries the final byte of a sample. `smp_data` and `smp_chan` are valid with it.
- R6: `cfg_chans` holds the channel count minus one. Successive samples take channel 0, 1, and so on up to `cfg_chans`, and the index then wraps to 0.
- R7: `cfg_width` selects the sample width: 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 3 bytes. Both `cfg_width` and `cfg_chans` are captured only in the cycle the sync bit falls. A change at any other time has no effect.
- R8: A write in the same cycle that `sync_bit` is first seen low is accepted as byte 0 of channel 0, under the newly captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| wr_en | input | 1 | Byte write strobe, one byte per cycle it is high |
| wr_data | input | 8 | Byte written to the PCM port |
| sync_bit | input | 1 | Channel-sync control bit; a high-then-low toggle realigns the stream |
| cfg_width | input | 2 | Sample width select (0: 1 byte, 1: 2 bytes, 2/3: 3 bytes) |
| cfg_chans | input | 3 | Channel count minus one |
| smp_data | output | 24 | Assembled sample, left-justified |
| smp_chan | output | 3 | Channel index of the sample |
| smp_valid | output | 1 | One-cycle pulse marking a completed sample |

## Verification
The assertions assume that the host changes `sync_bit` and the configuration inputs only at clock edges, never between them. They also assume `wr_en` is held low while reset is active. The checker then relies on each output pulse tracing back to a single accepted write, one cycle earlier. The bench drives every input on the falling clock edge and keeps `wr_en` low through reset. It holds `sync_bit` high for at least one full cycle on each toggle, so that every realignment is a clean high-then-low transition.

// File: rtl/pcmdi_pkg.sv
package pcmdi_pkg;
  localparam int BYTE_W    = 8;
  localparam int BYTES_MAX = 3;
  localparam int SMP_W     = BYTE_W * BYTES_MAX;
  localparam int IDX_W     = $clog2(BYTES_MAX);

  // number of bytes per sample, minus one
  function automatic logic [IDX_W-1:0] width_to_last(input logic [1:0] sel);
    case (sel)
      2'd0:    width_to_last = IDX_W'(0);
      2'd1:    width_to_last = IDX_W'(1);
      default: width_to_last = IDX_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/pcmdi_rst_sync.sv
module pcmdi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pcmdi_sync_ctrl.sv
module pcmdi_sync_ctrl
  import pcmdi_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             sync_bit,
  input  logic [1:0]       cfg_width,
  input  logic [CH_W-1:0]  cfg_chans,
  output logic             accept,
  output logic             realign,
  output logic [IDX_W-1:0] eff_last_byte,
  output logic [CH_W-1:0]  eff_last_chan,
  output logic [IDX_W-1:0] act_last_byte,
  output logic [CH_W-1:0]  act_last_chan
);
  logic             sync_q, sync_d;
  logic [IDX_W-1:0] lb_q, lb_d;
  logic [CH_W-1:0]  lc_q, lc_d;

  always_comb begin
    realign = sync_q & ~sync_bit;
    accept  = wr_en & ~sync_bit;
    sync_d  = sync_bit;
    lb_d    = lb_q;
    lc_d    = lc_q;
    if (realign) begin
      lb_d = width_to_last(cfg_width);
      lc_d = cfg_chans;
    end
    eff_last_byte = lb_d;
    eff_last_chan = lc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      lb_q   <= '0;
      lc_q   <= CH_W'(1);
    end else begin
      sync_q <= sync_d;
      lb_q   <= lb_d;
      lc_q   <= lc_d;
    end
  end

  assign act_last_byte = lb_q;
  assign act_last_chan = lc_q;
endmodule

// File: rtl/pcmdi_byte_pack.sv
module pcmdi_byte_pack
  import pcmdi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              realign,
  input  logic [IDX_W-1:0]  last_byte,
  input  logic [BYTE_W-1:0] data,
  output logic              done,
  output logic [SMP_W-1:0]  word
);
  logic [IDX_W-1:0] idx_q, idx_d, idx_eff;
  logic [SMP_W-1:0] acc_q, acc_d;
  logic             acc_en;

  always_comb begin
    idx_eff = realign ? '0 : idx_q;
    for (int b = 0; b < BYTES_MAX; b++) begin
      if (IDX_W'(b) < idx_eff)
        word[SMP_W-1-BYTE_W*b -: BYTE_W] = acc_q[SMP_W-1-BYTE_W*b -: BYTE_W];
      else if (IDX_W'(b) == idx_eff)
        word[SMP_W-1-BYTE_W*b -: BYTE_W] = data;
      else
        word[SMP_W-1-BYTE_W*b -: BYTE_W] = '0;
    end
    done   = accept && (idx_eff == last_byte);
    acc_en = accept;
    acc_d  = word;
    if (done)        idx_d = '0;
    else if (accept) idx_d = idx_eff + IDX_W'(1);
    else             idx_d = idx_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end
endmodule

// File: rtl/pcmdi_chan_seq.sv
module pcmdi_chan_seq
  import pcmdi_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             realign,
  input  logic [CH_W-1:0]  last_chan,
  input  logic [SMP_W-1:0] word,
  output logic [SMP_W-1:0] smp_data,
  output logic [CH_W-1:0]  smp_chan,
  output logic             smp_valid
);
  logic [CH_W-1:0]  chan_q, chan_d, chan_eff;
  logic [SMP_W-1:0] data_q;
  logic [CH_W-1:0]  ochan_q;
  logic             valid_q;

  always_comb begin
    chan_eff = realign ? '0 : chan_q;
    if (done) chan_d = (chan_eff == last_chan) ? '0 : chan_eff + CH_W'(1);
    else      chan_d = chan_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      chan_q  <= chan_d;
      valid_q <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ochan_q <= '0;
    end else if (done) begin
      data_q  <= word;
      ochan_q <= chan_eff;
    end
  end

  assign smp_data  = data_q;
  assign smp_chan  = ochan_q;
  assign smp_valid = valid_q;
endmodule

// File: rtl/pcm_byte_deinterleaver.sv
module pcm_byte_deinterleaver
  import pcmdi_pkg::*;
#(
  parameter int MAX_CH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_data,
  input  logic                       sync_bit,
  input  logic [1:0]                 cfg_width,
  input  logic [$clog2(MAX_CH)-1:0]  cfg_chans,
  output logic [23:0]                smp_data,
  output logic [$clog2(MAX_CH)-1:0]  smp_chan,
  output logic                       smp_valid
);
  localparam int CH_W = $clog2(MAX_CH);

  logic             rst_int_n;
  logic             accept, realign, done;
  logic [IDX_W-1:0] eff_last_byte, act_last_byte;
  logic [CH_W-1:0]  eff_last_chan, act_last_chan;
  logic [SMP_W-1:0] word;

  pcmdi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pcmdi_sync_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .wr_en         (wr_en),
    .sync_bit      (sync_bit),
    .cfg_width     (cfg_width),
    .cfg_chans     (cfg_chans),
    .accept        (accept),
    .realign       (realign),
    .eff_last_byte (eff_last_byte),
    .eff_last_chan (eff_last_chan),
    .act_last_byte (act_last_byte),
    .act_last_chan (act_last_chan)
  );

  pcmdi_byte_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .realign   (realign),
    .last_byte (eff_last_byte),
    .data      (wr_data),
    .done      (done),
    .word      (word)
  );

  pcmdi_chan_seq #(.CH_W(CH_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .done      (done),
    .realign   (realign),
    .last_chan (eff_last_chan),
    .word      (word),
    .smp_data  (smp_data),
    .smp_chan  (smp_chan),
    .smp_valid (smp_valid)
  );
endmodule

// File: rtl/pcmdi_checker.sv
module pcmdi_checker #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            sync_bit,
  input logic            smp_valid,
  input logic [23:0]     smp_data,
  input logic [CH_W-1:0] smp_chan,
  input logic [1:0]      act_last_byte,
  input logic [CH_W-1:0] act_last_chan
);
  AST_SYNC_HIGH_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_bit |=> !smp_valid); // R3

  AST_VALID_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(wr_en)); // R5

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp_chan <= act_last_chan)); // R6

  AST_ONE_BYTE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && act_last_byte == 2'd0) |-> (smp_data[15:0] == 16'h0)); // R4

  AST_TWO_BYTE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && act_last_byte == 2'd1) |-> (smp_data[7:0] == 8'h0)); // R4
endmodule

bind pcm_byte_deinterleaver pcmdi_checker #(.CH_W(CH_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .wr_en         (wr_en),
  .sync_bit      (sync_bit),
  .smp_valid     (smp_valid),
  .smp_data      (smp_data),
  .smp_chan      (smp_chan),
  .act_last_byte (act_last_byte),
  .act_last_chan (act_last_chan)
);

// File: tb/tb_pcm_byte_deinterleaver.sv
`timescale 1ns/1ps
module tb_pcm_byte_deinterleaver;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, sync_bit;
  logic [7:0]  wr_data;
  logic [1:0]  cfg_width;
  logic [2:0]  cfg_chans;
  logic [23:0] smp_data;
  logic [2:0]  smp_chan;
  logic        smp_valid;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  logic [23:0] cap_data [64];
  logic [2:0]  cap_chan [64];
  int cap_n = 0;
  int base;

  always #2.5 clk = ~clk;

  pcm_byte_deinterleaver dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sync_bit(sync_bit), .cfg_width(cfg_width), .cfg_chans(cfg_chans),
    .smp_data(smp_data), .smp_chan(smp_chan), .smp_valid(smp_valid)
  );

  always @(negedge clk) begin
    if (smp_valid && cap_n < 64) begin
      cap_data[cap_n] = smp_data;
      cap_chan[cap_n] = smp_chan;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic mark();
    @(posedge clk);
    base = cap_n;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic toggle_sync(input logic [1:0] w, input logic [2:0] c);
    @(negedge clk);
    cfg_width = w; cfg_chans = c; sync_bit = 1'b1;
    @(negedge clk);
    sync_bit = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_smp(input string req, input int k,
                            input logic [23:0] d, input logic [2:0] c);
    chk(req, int'(cap_data[base+k]), int'(d));
    chk(req, int'(cap_chan[base+k]), int'(c));
  endtask

  task automatic t_reset();
    chk("R1 valid", int'(smp_valid), 0);
    chk("R1 data", int'(smp_data), 0);
    chk("R1 chan", int'(smp_chan), 0);
  endtask

  task automatic t_default_cfg();  // R1: stereo 1-byte before any toggle
    mark();
    send(8'h5A); send(8'h6B);
    settle();
    chk("R1 count", cap_n - base, 2);
    expect_smp("R1", 0, 24'h5A0000, 3'd0);
    expect_smp("R1", 1, 24'h6B0000, 3'd1);
  endtask

  task automatic t_stereo8();  // R2 R5
    toggle_sync(2'd0, 3'd1);
    mark();
    send(8'hA1); send(8'hB2); send(8'hC3); send(8'hD4);
    settle();
    chk("R5 count", cap_n - base, 4);
    expect_smp("R2", 0, 24'hA10000, 3'd0);
    expect_smp("R5", 1, 24'hB20000, 3'd1);
    expect_smp("R5", 2, 24'hC30000, 3'd0);
    expect_smp("R5", 3, 24'hD40000, 3'd1);
  endtask

  task automatic t_stereo24();  // R4
    toggle_sync(2'd2, 3'd1);
    mark();
    send(8'h11); send(8'h22); send(8'h33);
    send(8'h44); send(8'h55); send(8'h66);
    settle();
    chk("R4 count", cap_n - base, 2);
    expect_smp("R4", 0, 24'h112233, 3'd0);
    expect_smp("R4", 1, 24'h445566, 3'd1);
  endtask

  task automatic t_three_ch16();  // R4 R6
    toggle_sync(2'd1, 3'd2);
    mark();
    for (int i = 0; i < 8; i++) send(8'(8'h10 + i));
    settle();
    chk("R6 count", cap_n - base, 4);
    expect_smp("R4", 0, 24'h101100, 3'd0);
    expect_smp("R6", 1, 24'h121300, 3'd1);
    expect_smp("R6", 2, 24'h141500, 3'd2);
    expect_smp("R6", 3, 24'h161700, 3'd0);
  endtask

  task automatic t_sync_discard();  // R3 R2
    toggle_sync(2'd0, 3'd1);
    mark();
    @(negedge clk) sync_bit = 1'b1;
    send(8'hEE); send(8'hEF);
    settle();
    chk("R3 discarded", cap_n - base, 0);
    @(negedge clk) sync_bit = 1'b0;
    @(negedge clk);
    send(8'h77);
    settle();
    chk("R3 count", cap_n - base, 1);
    expect_smp("R3", 0, 24'h770000, 3'd0);
  endtask

  task automatic t_mid_realign();  // R2
    toggle_sync(2'd2, 3'd1);
    mark();
    send(8'h01); send(8'h02);
    toggle_sync(2'd2, 3'd1);
    send(8'h0A); send(8'h0B); send(8'h0C);
    settle();
    chk("R2 count", cap_n - base, 1);
    expect_smp("R2", 0, 24'h0A0B0C, 3'd0);
  endtask

  task automatic t_cfg_hold();  // R7
    toggle_sync(2'd2, 3'd1);
    mark();
    @(negedge clk) cfg_width = 2'd0; cfg_chans = 3'd5;
    send(8'h21); send(8'h22); send(8'h23);
    send(8'h24); send(8'h25); send(8'h26);
    settle();
    chk("R7 count", cap_n - base, 2);
    expect_smp("R7", 0, 24'h212223, 3'd0);
    expect_smp("R7", 1, 24'h242526, 3'd1);
  endtask

  task automatic t_same_cycle();  // R8
    toggle_sync(2'd2, 3'd3);
    send(8'h99);  // partial sample, to be abandoned
    mark();
    @(negedge clk) cfg_width = 2'd0; cfg_chans = 3'd1; sync_bit = 1'b1;
    @(negedge clk) sync_bit = 1'b0; wr_en = 1'b1; wr_data = 8'h3C;
    @(negedge clk) wr_en = 1'b0;
    send(8'h3D);
    settle();
    chk("R8 count", cap_n - base, 2);
    expect_smp("R8", 0, 24'h3C0000, 3'd0);
    expect_smp("R8", 1, 24'h3D0000, 3'd1);
  endtask

  task automatic t_eight_wrap();  // R6
    toggle_sync(2'd3, 3'd7);
    mark();
    for (int i = 0; i < 27; i++) send(8'(i));
    settle();
    chk("R6 count8", cap_n - base, 9);
    for (int k = 0; k < 9; k++)
      expect_smp("R6", k, {8'(3*k), 8'(3*k+1), 8'(3*k+2)}, 3'(k % 8));
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; sync_bit = 1'b0;
    cfg_width = 2'd0; cfg_chans = 3'd1;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_default_cfg();
    t_stereo8();
    t_stereo24();
    t_three_ch16();
    t_sync_discard();
    t_mid_realign();
    t_cfg_hold();
    t_same_cycle();
    t_eight_wrap();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule